// File: doc/BRIEF.md
# Programmable LED Activity Driver

This block drives one network-activity LED pin from a 32-bit control register. Software picks any mix of five activity sources (transmit, receive, collision, jabber and receive-polarity fault). The LED lights whenever the OR of the enabled sources is true. Each source arrives as a single-cycle synchronous strobe. An optional stretcher holds the pin lit for a fixed number of cycles after the last activity, so that single-cycle strobes are visible to the eye.

Collision strobes are masked for a parameterized number of cycles after every end-of-transmission strobe. This hides the heartbeat test that follows each frame. The pin works either as an active-low open-drain output, shown as an output-enable plus data pair, or as an active-high push-pull output.

Software can read the unstretched OR result from a read-only status bit. Register writes take effect only while an external LED-programming enable is high.

Top module: `led_activity_drv`

## Requirements
- R1: The LED condition is the OR of the enabled sources. The enable bits are: bit 0 transmit, bit 1 receive, bit 2 collision, bit 3 jabber and bit 4 receive-polarity fault. A strobe on a disabled source has no effect, and several sources may be enabled at once.
- R2: Read bit 15 shows the current unstretched OR result in the same cycle as the strobes. Writes to bit 15 have no effect.
- R3: With polarity bit 14 at 0, an active LED gives pin_oe=1 and pin_data=0, and an inactive LED gives pin_oe=0 and pin_data=0.
- R4: With polarity bit 14 at 1, pin_oe stays 1 and pin_data equals the LED state. Bit 15 keeps the same sense in both polarities.
- R5: A write with led_prog_en=0 leaves every register bit unchanged.
- R6: After hard reset the register reads 0x0000_0093: transmit, receive, receive-polarity and stretch enabled; collision, jabber and polarity cleared.
- R7: After a tx_done strobe, a collision strobe does not set bit 15 in any of the following MASK_CYC cycles. In the cycle after that window it does set bit 15.
- R8: With stretch bit 7 at 1, the LED stays active for HOLD_CYC cycles after the OR falls. The count restarts on each new assertion.
- R9: With stretch bit 7 at 0, the LED follows the OR in the same cycle.
- R10: Bits 31:16, 13:8 and 6:5 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| led_prog_en | input | 1 | Global enable for register writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, including status bit 15 |
| act_tx | input | 1 | Transmit activity strobe |
| act_rx | input | 1 | Receive activity strobe |
| act_col | input | 1 | Collision activity strobe |
| act_jab | input | 1 | Jabber activity strobe |
| act_rxpol | input | 1 | Receive polarity fault strobe |
| tx_done | input | 1 | End-of-transmission strobe that starts the collision mask |
| pin_oe | output | 1 | LED pin output enable |
| pin_data | output | 1 | LED pin output level |

## Verification
The hardest state to reach is the edge of the collision mask window. The mask has no visible state of its own; it can only be seen through bit 15 while a collision strobe is present. The bench therefore enables only the collision source and turns the stretcher off. It then holds the collision strobe high from the cycle after tx_done onward and samples bit 15 in every cycle up to the first unmasked one. The stretcher is checked the same way: the bench counts lit cycles after a single-cycle pulse, then fires a second pulse in the middle of the hold to show the restart.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    localparam int SRC_N = 5;

    typedef enum logic [2:0] {
        SRC_TX    = 3'd0,
        SRC_RX    = 3'd1,
        SRC_COL   = 3'd2,
        SRC_JAB   = 3'd3,
        SRC_RXPOL = 3'd4
    } src_idx_e;

    localparam int BIT_STRETCH = 7;
    localparam int BIT_POL     = 14;
    localparam int BIT_STATUS  = 15;

    typedef struct packed {
        logic             pol;
        logic             stretch;
        logic [SRC_N-1:0] src_en;
    } led_cfg_t;

    localparam led_cfg_t CFG_RESET = '{pol: 1'b0, stretch: 1'b1, src_en: 5'b10011};

endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
    import led_drv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_ok,
    input  led_cfg_t wr_cfg,
    output led_cfg_t cfg
);

    typedef struct packed {
        led_cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.cfg = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/led_downtimer.sv
module led_downtimer #(
    parameter int LOAD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int W = $clog2(LOAD + 1);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = LOAD_V;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/led_activity_drv.sv
module led_activity_drv
    import led_drv_pkg::*;
#(
    parameter int MASK_CYC = 500,
    parameter int HOLD_CYC = 6250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        led_prog_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        act_tx,
    input  logic        act_rx,
    input  logic        act_col,
    input  logic        act_jab,
    input  logic        act_rxpol,
    input  logic        tx_done,
    output logic        pin_oe,
    output logic        pin_data
);

    led_cfg_t         cfg;
    led_cfg_t         wr_cfg;
    logic             col_masked;
    logic             hold_busy;
    logic [SRC_N-1:0] src_vec;
    logic [SRC_N-1:0] gated;
    logic             or_now;
    logic             led_active;
    logic             unused_wr_bits;

    assign wr_cfg.pol     = wr_data[BIT_POL];
    assign wr_cfg.stretch = wr_data[BIT_STRETCH];
    assign wr_cfg.src_en  = wr_data[SRC_N-1:0];
    assign unused_wr_bits = ^{wr_data[31:BIT_POL+1], wr_data[BIT_POL-1:BIT_STRETCH+1],
                              wr_data[BIT_STRETCH-1:SRC_N]};

    led_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_en & led_prog_en),
        .wr_cfg (wr_cfg),
        .cfg    (cfg)
    );

    led_downtimer #(.LOAD(MASK_CYC)) u_col_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_done),
        .busy  (col_masked)
    );

    always_comb begin
        src_vec            = '0;
        src_vec[SRC_TX]    = act_tx;
        src_vec[SRC_RX]    = act_rx;
        src_vec[SRC_COL]   = act_col & ~col_masked;
        src_vec[SRC_JAB]   = act_jab;
        src_vec[SRC_RXPOL] = act_rxpol;
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_gate
        assign gated[i] = cfg.src_en[i] & src_vec[i];
    end

    assign or_now = |gated;

    led_downtimer #(.LOAD(HOLD_CYC)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (or_now),
        .busy  (hold_busy)
    );

    assign led_active = or_now | (cfg.stretch & hold_busy);

    always_comb begin
        if (cfg.pol) begin
            pin_oe   = 1'b1;
            pin_data = led_active;
        end else begin
            pin_oe   = led_active;
            pin_data = 1'b0;
        end
    end

    always_comb begin
        rd_data              = '0;
        rd_data[SRC_N-1:0]   = cfg.src_en;
        rd_data[BIT_STRETCH] = cfg.stretch;
        rd_data[BIT_POL]     = cfg.pol;
        rd_data[BIT_STATUS]  = or_now;
    end

endmodule

// File: rtl/led_activity_chk.sv
module led_activity_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        led_prog_en,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        pin_oe,
    input logic        pin_data
);

    logic lit;
    assign lit = pin_oe && (pin_data == rd_data[14]);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:16] == 16'h0) && (rd_data[13:8] == 6'h0) && (rd_data[6:5] == 2'b00));

    // R5
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !led_prog_en) |=> $stable(rd_data[14:0]));

    // R3
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[14] |-> (!pin_data && (pin_oe || !rd_data[15])));

    // R4
    push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14] |-> (pin_oe && (rd_data[15] -> pin_data)));

    // R9
    no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> (lit == rd_data[15]));

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_data[15]) && rd_data[7]) |-> lit);

endmodule

bind led_activity_drv led_activity_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .led_prog_en (led_prog_en),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .pin_oe      (pin_oe),
    .pin_data    (pin_data)
);

// File: tb/led_activity_drv_bench.sv
`timescale 1ns/1ps
module led_activity_drv_bench;

    localparam int MASK = 20;
    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        led_prog_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        act_tx = 1'b0, act_rx = 1'b0, act_col = 1'b0, act_jab = 1'b0, act_rxpol = 1'b0;
    logic        tx_done = 1'b0;
    logic        pin_oe, pin_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    led_activity_drv #(.MASK_CYC(MASK), .HOLD_CYC(HOLD)) u_led_activity_drv (
        .clk(clk), .rst_n(rst_n), .led_prog_en(led_prog_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .act_tx(act_tx), .act_rx(act_rx),
        .act_col(act_col), .act_jab(act_jab), .act_rxpol(act_rxpol),
        .tx_done(tx_done), .pin_oe(pin_oe), .pin_data(pin_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [31:0] v);
        next_cyc();
        wr_en = 1'b1;
        wr_data = v;
        next_cyc();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R6 reset value", rd_data, 32'h0000_0093);
        chk("R3 idle pin released", {31'b0, pin_oe}, 32'd0);
        chk("R10 upper bits zero", {16'b0, rd_data[31:16]}, 32'd0);
    endtask

    task automatic t_or_sources();
        led_prog_en = 1'b1;
        write_reg(32'h0000_0003);
        act_rx = 1'b1;
        @(negedge clk);
        chk("R1 rx enabled lights", {30'b0, pin_oe, pin_data}, 32'd2);
        chk("R2 status follows or", {31'b0, rd_data[15]}, 32'd1);
        next_cyc();
        act_tx = 1'b1;
        @(negedge clk);
        chk("R1 tx and rx together", {31'b0, rd_data[15]}, 32'd1);
        next_cyc();
        act_tx = 1'b0;
        act_rx = 1'b0;
        act_jab = 1'b1;
        act_rxpol = 1'b1;
        @(negedge clk);
        chk("R1 disabled sources ignored", {31'b0, rd_data[15]}, 32'd0);
        chk("R3 inactive pin released", {30'b0, pin_oe, pin_data}, 32'd0);
        next_cyc();
        act_jab = 1'b0;
        act_rxpol = 1'b0;
    endtask

    task automatic t_readonly();
        write_reg(32'hFFFF_BF61 & ~32'h0000_4000 | 32'h0000_8000);
        @(negedge clk);
        chk("R10 R2 reserved and status ignored on write", rd_data, 32'h0000_0001);
    endtask

    task automatic t_lock();
        led_prog_en = 1'b0;
        write_reg(32'h0000_409C);
        @(negedge clk);
        chk("R5 write blocked", rd_data, 32'h0000_0001);
        led_prog_en = 1'b1;
    endtask

    task automatic t_polarity();
        write_reg(32'h0000_4001);
        @(negedge clk);
        chk("R4 idle push-pull low", {30'b0, pin_oe, pin_data}, 32'd2);
        next_cyc();
        act_tx = 1'b1;
        @(negedge clk);
        chk("R4 active push-pull high", {30'b0, pin_oe, pin_data}, 32'd3);
        chk("R4 status sense unchanged", {31'b0, rd_data[15]}, 32'd1);
        next_cyc();
        act_tx = 1'b0;
    endtask

    task automatic t_stretch();
        write_reg(32'h0000_0081);
        act_tx = 1'b1;
        @(negedge clk);
        chk("R8 lit during pulse", {31'b0, pin_oe}, 32'd1);
        for (int k = 1; k <= HOLD; k++) begin
            next_cyc();
            act_tx = 1'b0;
            @(negedge clk);
            chk("R8 held after pulse", {31'b0, pin_oe}, 32'd1);
            if (k == 1) chk("R2 status unstretched", {31'b0, rd_data[15]}, 32'd0);
        end
        next_cyc();
        @(negedge clk);
        chk("R8 released after hold", {31'b0, pin_oe}, 32'd0);
        next_cyc();
        act_tx = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            next_cyc();
            act_tx = 1'b0;
        end
        act_tx = 1'b1;
        for (int k = 1; k <= HOLD; k++) begin
            next_cyc();
            act_tx = 1'b0;
            @(negedge clk);
            chk("R8 restart holds", {31'b0, pin_oe}, 32'd1);
        end
        next_cyc();
        @(negedge clk);
        chk("R8 released after restart", {31'b0, pin_oe}, 32'd0);
    endtask

    task automatic t_no_stretch();
        write_reg(32'h0000_0001);
        act_tx = 1'b1;
        @(negedge clk);
        chk("R9 lit with or", {31'b0, pin_oe}, 32'd1);
        next_cyc();
        act_tx = 1'b0;
        @(negedge clk);
        chk("R9 dark right after", {31'b0, pin_oe}, 32'd0);
    endtask

    task automatic t_col_mask();
        write_reg(32'h0000_0004);
        tx_done = 1'b1;
        for (int k = 1; k <= MASK; k++) begin
            next_cyc();
            tx_done = 1'b0;
            act_col = 1'b1;
            @(negedge clk);
            if (k == 1 || k == MASK) chk("R7 collision masked", {31'b0, rd_data[15]}, 32'd0);
        end
        next_cyc();
        @(negedge clk);
        chk("R7 collision after window", {31'b0, rd_data[15]}, 32'd1);
        chk("R3 open-drain pulls low", {30'b0, pin_oe, pin_data}, 32'd2);
        next_cyc();
        act_col = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_or_sources();
        t_readonly();
        t_lock();
        t_polarity();
        t_stretch();
        t_no_stretch();
        t_col_mask();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule